// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is the master side of a synchronous serial link in which each word is announced by a single high pulse on a frame-sync line, one serial clock period wide. Software-side logic drops parallel words into an eight-entry transmit queue. The block turns each word into a frame, sending it most significant bit first. At the same time it collects one word from the slave and places it in an eight-entry receive queue. The word length can be set anywhere from 4 to 16 bits. The serial clock comes from dividing the system clock.

Timing on the serial side is simple. Data is launched on rising edges of the serial clock and sampled on falling edges. If the transmit queue still holds a word when a frame ends, the next frame-sync pulse overlaps the last bit, so a burst of words goes out with no gap between them. When the link is idle, the clock and frame-sync lines sit low and the data output is released. A receive-timeout flag shows that received words have been sitting unread while the link stays quiet.

Top module: `fsync_ser_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ser_clk`, `ser_fs` and `ser_dout_oe` are 0. After reset both queues are empty and both overrun flags are 0.
- R2: While idle, a non-empty transmit queue starts a frame. `ser_fs` rises in the same cycle as a rising edge of `ser_clk`, and it falls at the next rising edge, so it is high for exactly one serial clock period.
- R3: The word is latched with `cfg_bits` (4..16) fixed for the frame. It is sent from its low `cfg_bits` bits, MSB first. The MSB appears on the rising edge after the frame-sync edge, and each later rising edge presents the next bit.
- R4: `ser_din` is sampled on each falling edge of the data periods. The word is right-justified, with its unused upper bits 0. It is written to the receive queue at the point where the rising edge after the LSB period falls.
- R5: The serial clock period is 2*max(`cfg_half`,1) system clock cycles, so the ratio is never below 2.
- R6: The serial clock toggles only during frames. A burst of k frames shows exactly 1 + k*`cfg_bits` rising edges. No rising edge follows the last LSB period, and the link then goes idle.
- R7: When the transmit queue is non-empty at the rising edge that presents an LSB, `ser_fs` pulses during that LSB period. The next word's MSB follows on the next rising edge, and `ser_dout_oe` stays high for the whole burst.
- R8: Each queue holds 8 words and is first in, first out, with full and empty flags. `rx_data` shows the oldest received word, and `rx_rd` removes it. `rx_rd` on an empty queue has no effect.
- R9: A `tx_wr` while the transmit queue is full drops the word and sets `ovr_tx`. The flag stays set until reset.
- R10: A received word that arrives while the receive queue is full is dropped and sets `ovr_rx`. The flag stays set until reset.
- R11: `rx_timeout` is 1 only while no frame is in progress, the receive queue is non-empty, and that condition has lasted at least `cfg_timeout` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bits | input | 5 | Word length in bits, 4..16 |
| cfg_half | input | 8 | System cycles per serial clock half period (0 acts as 1) |
| cfg_timeout | input | 16 | Idle cycles before the receive timeout is raised |
| tx_wr | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| ovr_tx | output | 1 | Sticky transmit overrun |
| rx_rd | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| ovr_rx | output | 1 | Sticky receive overrun |
| rx_timeout | output | 1 | Unread data while the link is idle |
| ser_clk | output | 1 | Serial clock |
| ser_fs | output | 1 | Frame-sync pulse |
| ser_dout | output | 1 | Serial data to the slave |
| ser_dout_oe | output | 1 | Output enable for `ser_dout` |
| ser_din | input | 1 | Serial data from the slave |

## Verification
The bench aims at frame boundaries. It uses bursts in which the frame-sync pulse must overlap an LSB period. A design that reloads the shifter too early would corrupt that last bit, and one that idles between words would show extra rising edges and an extra drop of the output enable. Word lengths 4 and 16 and a divider setting of 0 expose masking or shift-amount errors and a clock faster than half the system rate. A twelve-word burst fills both queues, which catches an off-by-one in the full test or a flag that clears itself. An `rx_rd` on an empty queue would corrupt the read pointer in a faulty design, and the read-back of the following frame exposes that.

// File: rtl/fsync_ser_master.sv
module fsync_ser_master #(
  parameter int W      = 16,
  parameter int DEPTH  = 8,
  parameter int HALF_W = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cfg_bits,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic              tx_wr,
  input  logic [W-1:0]      tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              ovr_tx,
  input  logic              rx_rd,
  output logic [W-1:0]      rx_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              ovr_rx,
  output logic              rx_timeout,
  output logic              ser_clk,
  output logic              ser_fs,
  output logic              ser_dout,
  output logic              ser_dout_oe,
  input  logic              ser_din
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] txm [DEPTH];
  logic [W-1:0] rxm [DEPTH];
  logic [AW:0]  txw, txr, rxw, rxr;

  logic              active, sclk_q, fs_q, dout_q, ovl;
  logic [4:0]        cnt, nb, nb_nx;
  logic [W-1:0]      txsh, rxsh;
  logic [HALF_W-1:0] div;
  logic [TO_W-1:0]   to_cnt;

  assign tx_empty = (txw == txr);
  assign tx_full  = (txw[AW] != txr[AW]) && (txw[AW-1:0] == txr[AW-1:0]);
  assign rx_empty = (rxw == rxr);
  assign rx_full  = (rxw[AW] != rxr[AW]) && (rxw[AW-1:0] == rxr[AW-1:0]);
  assign rx_data  = rxm[rxr[AW-1:0]];

  wire [HALF_W-1:0] half_eff = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
  wire tick      = active && (div == half_eff - HALF_W'(1));
  wire rise      = tick && !sclk_q;
  wire fall      = tick && sclk_q;
  wire start     = !active && !tx_empty;
  wire last_rise = rise && (cnt == nb);
  wire lsb_rise  = rise && (cnt + 5'd1 == nb);
  wire load      = start || (lsb_rise && !tx_empty);
  wire tx_push   = tx_wr && !tx_full;
  wire rx_push   = last_rise && !rx_full;
  wire rx_pop    = rx_rd && !rx_empty;
  wire [W-1:0] mask    = (W'(1) << nb) - W'(1);
  wire [W-1:0] tx_head = txm[txr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (tx_push) txm[txw[AW-1:0]] <= tx_data;
    if (rx_push) rxm[rxw[AW-1:0]] <= rxsh & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txw <= '0; txr <= '0; rxw <= '0; rxr <= '0;
      ovr_tx <= 1'b0; ovr_rx <= 1'b0; to_cnt <= '0;
    end else begin
      if (tx_push) txw <= txw + 1'b1;
      if (load)    txr <= txr + 1'b1;
      if (rx_push) rxw <= rxw + 1'b1;
      if (rx_pop)  rxr <= rxr + 1'b1;
      if (tx_wr && tx_full)     ovr_tx <= 1'b1;
      if (last_rise && rx_full) ovr_rx <= 1'b1;
      if (active || rx_empty) to_cnt <= '0;
      else if (to_cnt != '1)  to_cnt <= to_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sclk_q <= 1'b0; fs_q <= 1'b0; dout_q <= 1'b0; ovl <= 1'b0;
      cnt <= '0; nb <= 5'd4; nb_nx <= 5'd4; div <= '0; txsh <= '0; rxsh <= '0;
    end else begin
      if (start) begin
        active <= 1'b1; sclk_q <= 1'b1; fs_q <= 1'b1; dout_q <= 1'b0;
        div <= '0; cnt <= '0; nb <= cfg_bits; ovl <= 1'b0;
      end else if (active) begin
        div <= tick ? '0 : div + 1'b1;
        if (rise) begin
          if (cnt == nb) begin
            if (ovl) begin
              sclk_q <= 1'b1; fs_q <= 1'b0; dout_q <= txsh[W-1];
              txsh <= txsh << 1; cnt <= 5'd1; nb <= nb_nx; ovl <= 1'b0;
            end else begin
              active <= 1'b0; dout_q <= 1'b0;
            end
          end else begin
            sclk_q <= 1'b1; fs_q <= 1'b0; dout_q <= txsh[W-1];
            txsh <= txsh << 1; cnt <= cnt + 5'd1;
            if (load) begin
              fs_q <= 1'b1; ovl <= 1'b1; nb_nx <= cfg_bits;
            end
          end
        end
        if (fall) begin
          sclk_q <= 1'b0;
          if (cnt != '0) rxsh <= {rxsh[W-2:0], ser_din};
        end
      end
      if (load) txsh <= tx_head << (W - int'(cfg_bits));
    end
  end

  assign ser_clk     = sclk_q;
  assign ser_fs      = fs_q;
  assign ser_dout    = dout_q;
  assign ser_dout_oe = active;
  assign rx_timeout  = !active && !rx_empty && (to_cnt >= cfg_timeout);
endmodule

module fsync_ser_master_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr,
  input logic tx_full,
  input logic ovr_tx,
  input logic ovr_rx,
  input logic rx_empty,
  input logic rx_timeout,
  input logic ser_clk,
  input logic ser_fs,
  input logic ser_dout_oe
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_oe |-> (!ser_clk && !ser_fs));
  a_r2_fs_rise_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_fs) |-> $rose(ser_clk));
  a_r2_fs_fall_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_fs) |-> $rose(ser_clk));
  a_r9_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> ovr_tx);
  a_r9_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_tx |=> ovr_tx);
  a_r10_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_rx |=> ovr_rx);
  a_r11_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> (!ser_dout_oe && !rx_empty));
endmodule

bind fsync_ser_master fsync_ser_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_full(tx_full), .ovr_tx(ovr_tx),
  .ovr_rx(ovr_rx), .rx_empty(rx_empty), .rx_timeout(rx_timeout),
  .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_dout_oe(ser_dout_oe)
);

// File: tb/fsync_ser_master_bench.sv
module fsync_ser_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cfg_bits = 5'd8;
  logic [7:0] cfg_half = 8'd2;
  logic [15:0] cfg_timeout = 16'd1000;
  logic tx_wr = 1'b0, rx_rd = 1'b0, din = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_full, tx_empty, ovr_tx, rx_full, rx_empty, ovr_rx, rx_timeout;
  logic [15:0] rx_data;
  logic sclk, fs, dout, oe;

  fsync_ser_master u_fsync_ser_master (
    .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .cfg_half(cfg_half),
    .cfg_timeout(cfg_timeout), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .ovr_tx(ovr_tx), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty), .ovr_rx(ovr_rx),
    .rx_timeout(rx_timeout), .ser_clk(sclk), .ser_fs(fs), .ser_dout(dout),
    .ser_dout_oe(oe), .ser_din(din));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_tx[$];
  logic [15:0] exp_rx[$];

  function automatic logic [15:0] msk(logic [15:0] w, int n);
    return (n >= 16) ? w : (w & ((16'd1 << n) - 16'd1));
  endfunction
  function automatic int period_of(logic [7:0] h);
    return 2 * ((h == 0) ? 1 : int'(h));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor and slave model
  int cyc = 0, last_rise_cyc = 0, rises = 0, frames = 0, oe_falls = 0;
  int ccount = 0, sidx = -1;
  bit prev_sclk = 0, prev_oe = 0, last_fs = 0, in_frame = 0, cap_on = 0;
  logic [15:0] cap = '0, sw = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!oe) chk(!sclk && !fs, "R1", "idle lines", {sclk, fs}, 0);
      if (sclk && !prev_sclk) begin
        chk(oe, "R6", "clock edge outside frame", oe, 1);
        if (in_frame) begin
          chk(cyc - last_rise_cyc == period_of(cfg_half), "R5", "clock period",
              cyc - last_rise_cyc, period_of(cfg_half));
          chk(!(last_fs && fs), "R2", "fs longer than one period", fs, 0);
        end else begin
          chk(fs, "R2", "fs at frame start", fs, 1);
        end
        in_frame = 1; last_rise_cyc = cyc; rises++;
        if (last_fs) begin
          sw = msk(16'($urandom), int'(cfg_bits));
          exp_rx.push_back(sw);
          sidx = int'(cfg_bits) - 1;
          din <= sw[sidx];
          cap_on = 1; ccount = 0; cap = '0; frames++;
        end else if (sidx > 0) begin
          sidx--;
          din <= sw[sidx];
        end
        last_fs = fs;
      end
      if (!sclk && prev_sclk && cap_on) begin
        cap = {cap[14:0], dout}; ccount++;
        if (ccount == int'(cfg_bits)) begin
          cap_on = 0;
          if (exp_tx.size() == 0) chk(0, "R3", "unexpected word", cap, 0);
          else begin
            logic [15:0] e;
            e = exp_tx.pop_front();
            chk(cap == e, "R3", "serial word", cap, e);
          end
        end
      end
      if (prev_oe && !oe) begin
        oe_falls++;
        chk(rises == 1 + frames * int'(cfg_bits), "R6", "rising edges in burst",
            rises, 1 + frames * int'(cfg_bits));
        rises = 0; frames = 0; in_frame = 0; last_fs = 0; sidx = -1;
      end
    end
    prev_sclk = sclk; prev_oe = oe;
  end

  task automatic burst(int k, bit rnd, logic [15:0] w0, int keep);
    for (int i = 0; i < k; i++) begin
      logic [15:0] w;
      w = rnd ? 16'($urandom) : (w0 ^ 16'(i * 16'h1357));
      @(negedge clk); tx_wr = 1; tx_data = w;
      if (i < keep) exp_tx.push_back(msk(w, int'(cfg_bits)));
    end
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (oe || !tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(string req);
    while (!rx_empty) begin
      logic [15:0] e;
      @(negedge clk);
      e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 16'hDEAD;
      chk(rx_data == e, req, "received word", rx_data, e);
      rx_rd = 1;
      @(negedge clk); rx_rd = 0;
    end
  endtask

  task automatic one(int nb, int half, logic [15:0] w, string req);
    int f0;
    cfg_bits = 5'(nb); cfg_half = 8'(half);
    f0 = oe_falls;
    burst(1, 0, w, 1);
    wait_idle();
    chk(oe_falls == f0 + 1, req, "single frame window", oe_falls - f0, 1);
    drain("R4");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!sclk && !fs && !oe, "R1", "reset lines", {sclk, fs, oe}, 0);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1", "reset queues",
        {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk(!ovr_tx && !ovr_rx, "R1", "reset overrun", {ovr_tx, ovr_rx}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    one(8, 2, 16'h00A5, "R3");
    one(16, 1, 16'h8001, "R3");
    one(4, 0, 16'hFFF9, "R5");
    one(16, 3, 16'hFFFF, "R4");

    // R8: read on empty queue is ignored
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk(rx_empty, "R8", "empty after read on empty", rx_empty, 1);
    one(12, 2, 16'h0C3A, "R8");
    chk(rx_empty, "R8", "empty after drain", rx_empty, 1);

    // R7: back-to-back burst keeps one window
    begin
      int f0;
      cfg_bits = 5'd6; cfg_half = 8'd1; f0 = oe_falls;
      burst(4, 1, '0, 4);
      wait_idle();
      chk(oe_falls == f0 + 1, "R7", "burst without gap", oe_falls - f0, 1);
      drain("R7");
    end

    // R9, R10: fill both queues
    cfg_bits = 5'd16; cfg_half = 8'd3;
    burst(12, 0, 16'h6B21, 9);
    chk(ovr_tx, "R9", "tx overrun flag", ovr_tx, 1);
    wait_idle();
    chk(ovr_tx, "R9", "tx overrun sticky", ovr_tx, 1);
    chk(rx_full && ovr_rx, "R10", "rx full and overrun", {rx_full, ovr_rx}, 2'b11);
    begin
      logic [15:0] keep8[$];
      for (int i = 0; i < 8; i++) keep8.push_back(exp_rx[i]);
      chk(exp_rx.size() == 9, "R10", "frames seen", exp_rx.size(), 9);
      exp_rx = keep8;
    end
    drain("R10");
    chk(ovr_rx && rx_empty, "R10", "rx overrun sticky", {ovr_rx, rx_empty}, 2'b11);

    // R11: receive timeout
    cfg_timeout = 16'd40;
    cfg_bits = 5'd5; cfg_half = 8'd1;
    burst(1, 1, '0, 1);
    @(negedge clk);
    while (oe) begin
      chk(!rx_timeout, "R11", "timeout during frame", rx_timeout, 0);
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk(!rx_timeout, "R11", "timeout too early", rx_timeout, 0);
    repeat (50) @(negedge clk);
    chk(rx_timeout, "R11", "timeout raised", rx_timeout, 1);
    drain("R11");
    chk(!rx_timeout, "R11", "timeout clears when empty", rx_timeout, 0);
    cfg_timeout = 16'd1000;

    // random bursts
    for (int it = 0; it < 30; it++) begin
      int f0, k;
      cfg_bits = 5'(4 + $urandom % 13);
      cfg_half = 8'($urandom % 4);
      k = 1 + $urandom % 5;
      f0 = oe_falls;
      burst(k, 1, '0, k);
      wait_idle();
      chk(oe_falls == f0 + 1, "R7", "random burst window", oe_falls - f0, 1);
      drain("R4");
    end
    chk(exp_tx.size() == 0, "R3", "all words sent", exp_tx.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule